// File: doc/BRIEF.md
# Fractional-Duty Pulse Width Modulator

This block drives one pulse-width-modulated output whose period and active time are counted in ticks of a PWM clock enable. The period is an 8-bit count of ticks. The active time is an 8-bit whole-tick duty plus a 2-bit fraction. The fraction is spread over a rolling group of four periods, so that the average active time resolves to a quarter of a tick.

Software loads the values one nibble at a time through write strobes. Each multi-nibble value is gathered in staging registers and committed as one value when its upper nibble is written. A committed value reaches the running waveform only at the next period boundary, so an update never truncates or stretches the period in progress. A polarity input chooses whether the active portion is driven high or low.

Top module: `pwmfrac_top`

## Requirements
- R1: While the applied period value P is non-zero, each period lasts exactly P ticks, where a tick is a clock edge with `tickEn` high.
- R2: The active portion comes first in each period and lasts the applied duty value D in ticks, when no extra tick applies and D is less than P.
- R3: Periods carry a group index 0,1,2,3 that advances by one per period and wraps. The first period after a start from a zero period has index 0. With applied fraction F (taken from `wrData[1:0]` on a fraction write), a period whose index is 4−F or higher gets one extra active tick, and F=0 adds nothing. For example, D=7F hex with F=3 gives 7F, 80, 80, 80.
- R4: With `polarity` at 0 the active level is high and the idle level is low. With `polarity` at 1 both levels are inverted.
- R5: Committed period, duty and fraction values take effect only at the next period boundary. The period in progress keeps its old values.
- R6: When D plus any extra tick is P or more, the output is active for the whole period. When D=0 and no extra tick applies, the output is never active.
- R7: An applied period of 0 stops the counter, holds the output at the idle level and holds the group index at 0.
- R8: The period is written as a lower nibble (`wrPeriodLo`, `wrData[3:0]`) followed by an upper nibble (`wrPeriodHi`). Only the upper-nibble write commits {upper, staged lower}. Duty is written the same way with `wrDutyLo` and `wrDutyHi`, and the upper-nibble duty write also commits the staged fraction. Staged writes that are never committed have no effect.
- R9: The period counter and the group index advance only on ticks. Cycles with `tickEn` low leave the waveform unchanged.
- R10: After reset, all staged, committed and applied values are 0, so the output sits at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | PWM clock enable; one tick per high cycle |
| wrData | input | 4 | Nibble written by the strobes |
| wrPeriodLo | input | 1 | Stage the lower period nibble |
| wrPeriodHi | input | 1 | Write the upper period nibble and commit the period |
| wrDutyLo | input | 1 | Stage the lower duty nibble |
| wrDutyHi | input | 1 | Write the upper duty nibble and commit duty and fraction |
| wrFrac | input | 1 | Stage the 2-bit fraction from wrData[1:0] |
| polarity | input | 1 | 0: active high, 1: active low |
| pwmOut | output | 1 | PWM output level |

## Verification
Each period of a four-period group is measured by counting its active and idle ticks and by checking that the active portion comes first. This is done for every fraction value, so that an index threshold that is off by one shows up as the wrong period receiving the extra tick. Saturation settings (a duty equal to the period, and a duty one below it with a fraction) and a zero duty separate clipping from wrap-around. A zero period shows the idle hold. Settings are changed mid-period, and staged nibbles are left uncommitted, to show that updates wait for the boundary and for the upper nibble. A run with `tickEn` high only every other cycle, and a run with inverted polarity, show that timing follows ticks rather than clocks and that only the levels invert.

// File: rtl/pwmfrac_pkg.sv
package pwmfrac_pkg;
  localparam int PERIOD_W = 8;
  localparam int NIB_W    = 4;
  localparam int FRAC_W   = 2;

  typedef struct packed {
    logic loadActive;  // copy committed values into the applied set
    logic advance;     // a running period just ended: step the group index
  } pwmStrobe_t;
endpackage

// File: rtl/pwmfrac_regs.sv
module pwmfrac_regs
  import pwmfrac_pkg::*;
#(
  parameter int PERIOD_W = pwmfrac_pkg::PERIOD_W,
  parameter int NIB_W    = pwmfrac_pkg::NIB_W,
  parameter int FRAC_W   = pwmfrac_pkg::FRAC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NIB_W-1:0]    wrData,
  input  logic                wrPeriodLo,
  input  logic                wrPeriodHi,
  input  logic                wrDutyLo,
  input  logic                wrDutyHi,
  input  logic                wrFrac,
  output logic [PERIOD_W-1:0] pendPeriod,
  output logic [PERIOD_W-1:0] pendDuty,
  output logic [FRAC_W-1:0]   pendFrac
);
  localparam int HI_W = PERIOD_W - NIB_W;

  logic [NIB_W-1:0]  stagePerLo;
  logic [NIB_W-1:0]  stageDutyLo;
  logic [FRAC_W-1:0] stageFrac;

  // staging of the lower nibbles and the fraction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagePerLo  <= '0;
      stageDutyLo <= '0;
      stageFrac   <= '0;
    end else begin
      if (wrPeriodLo) stagePerLo  <= wrData;
      if (wrDutyLo)   stageDutyLo <= wrData;
      if (wrFrac)     stageFrac   <= wrData[FRAC_W-1:0];
    end
  end

  // commit on the upper-nibble writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPeriod <= '0;
      pendDuty   <= '0;
      pendFrac   <= '0;
    end else begin
      if (wrPeriodHi) pendPeriod <= {wrData[HI_W-1:0], stagePerLo};
      if (wrDutyHi) begin
        pendDuty <= {wrData[HI_W-1:0], stageDutyLo};
        pendFrac <= stageFrac;
      end
    end
  end

  AST_PERIOD_COMMIT_ONLY_HI: assert property (@(posedge clk) disable iff (!rstN)
    !wrPeriodHi |=> $stable(pendPeriod)); // R8
  AST_DUTY_COMMIT_ONLY_HI: assert property (@(posedge clk) disable iff (!rstN)
    !wrDutyHi |=> ($stable(pendDuty) && $stable(pendFrac))); // R8
endmodule

// File: rtl/pwmfrac_ctrl.sv
module pwmfrac_ctrl
  import pwmfrac_pkg::*;
#(
  parameter int PERIOD_W = pwmfrac_pkg::PERIOD_W,
  parameter int FRAC_W   = pwmfrac_pkg::FRAC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [PERIOD_W-1:0] actPeriod,
  output logic [PERIOD_W-1:0] cnt,
  output logic [FRAC_W-1:0]   cycIdx,
  output pwmStrobe_t          strobe
);
  logic stopped;
  logic lastTick;

  always_comb begin
    stopped           = (actPeriod == '0);
    lastTick          = !stopped && (cnt == actPeriod - 1'b1);
    strobe.advance    = tickEn && lastTick;
    strobe.loadActive = tickEn && (stopped || lastTick);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (tickEn) begin
      if (stopped || lastTick) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cycIdx <= '0;
    else if (stopped)        cycIdx <= '0;
    else if (strobe.advance) cycIdx <= cycIdx + 1'b1;
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod != '0) |-> (cnt < actPeriod)); // R1
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && actPeriod != '0) |=> (cycIdx == $past(cycIdx) + 1'b1) || (actPeriod == '0)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(cnt) && $stable(cycIdx)) || (actPeriod == '0)); // R9
  AST_STOP_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod == '0) |-> (cnt == '0)); // R7
  AST_STOP_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod == '0) |=> (cycIdx == '0)); // R7
endmodule

// File: rtl/pwmfrac_datapath.sv
module pwmfrac_datapath
  import pwmfrac_pkg::*;
#(
  parameter int PERIOD_W = pwmfrac_pkg::PERIOD_W,
  parameter int FRAC_W   = pwmfrac_pkg::FRAC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwmStrobe_t          strobe,
  input  logic [PERIOD_W-1:0] pendPeriod,
  input  logic [PERIOD_W-1:0] pendDuty,
  input  logic [FRAC_W-1:0]   pendFrac,
  input  logic [PERIOD_W-1:0] cnt,
  input  logic [FRAC_W-1:0]   cycIdx,
  input  logic                polarity,
  output logic [PERIOD_W-1:0] actPeriod,
  output logic                pwmOut
);
  localparam int GROUP = 1 << FRAC_W;

  logic [PERIOD_W-1:0] actDuty;
  logic [FRAC_W-1:0]   actFrac;
  logic                extraTick;
  logic [PERIOD_W:0]   activeLen;
  logic                activeLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPeriod <= '0;
      actDuty   <= '0;
      actFrac   <= '0;
    end else if (strobe.loadActive) begin
      actPeriod <= pendPeriod;
      actDuty   <= pendDuty;
      actFrac   <= pendFrac;
    end
  end

  always_comb begin
    extraTick = (actFrac != '0) &&
                ({1'b0, cycIdx} >= (FRAC_W+1)'(GROUP) - {1'b0, actFrac});
    activeLen = {1'b0, actDuty} + {{PERIOD_W{1'b0}}, extraTick};
    activeLvl = (actPeriod != '0) && ({1'b0, cnt} < activeLen);
    pwmOut    = activeLvl ^ polarity;
  end

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadActive |=> ($stable(actPeriod) && $stable(actDuty) && $stable(actFrac))); // R5
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod == '0) |-> (pwmOut == polarity)); // R7
  AST_FULL_WHEN_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod != '0 && actDuty >= actPeriod) |-> (pwmOut != polarity)); // R6
  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (actDuty == '0 && actFrac == '0) |-> (pwmOut == polarity)); // R6
endmodule

// File: rtl/pwmfrac_top.sv
module pwmfrac_top
  import pwmfrac_pkg::*;
#(
  parameter int PERIOD_W = pwmfrac_pkg::PERIOD_W,
  parameter int NIB_W    = pwmfrac_pkg::NIB_W,
  parameter int FRAC_W   = pwmfrac_pkg::FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [NIB_W-1:0] wrData,
  input  logic             wrPeriodLo,
  input  logic             wrPeriodHi,
  input  logic             wrDutyLo,
  input  logic             wrDutyHi,
  input  logic             wrFrac,
  input  logic             polarity,
  output logic             pwmOut
);
  logic [PERIOD_W-1:0] pendPeriod;
  logic [PERIOD_W-1:0] pendDuty;
  logic [FRAC_W-1:0]   pendFrac;
  logic [PERIOD_W-1:0] actPeriod;
  logic [PERIOD_W-1:0] cnt;
  logic [FRAC_W-1:0]   cycIdx;
  pwmStrobe_t          strobe;

  pwmfrac_regs #(.PERIOD_W(PERIOD_W), .NIB_W(NIB_W), .FRAC_W(FRAC_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrData(wrData),
    .wrPeriodLo(wrPeriodLo), .wrPeriodHi(wrPeriodHi),
    .wrDutyLo(wrDutyLo), .wrDutyHi(wrDutyHi), .wrFrac(wrFrac),
    .pendPeriod(pendPeriod), .pendDuty(pendDuty), .pendFrac(pendFrac)
  );

  pwmfrac_ctrl #(.PERIOD_W(PERIOD_W), .FRAC_W(FRAC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .actPeriod(actPeriod),
    .cnt(cnt), .cycIdx(cycIdx), .strobe(strobe)
  );

  pwmfrac_datapath #(.PERIOD_W(PERIOD_W), .FRAC_W(FRAC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pendPeriod(pendPeriod), .pendDuty(pendDuty), .pendFrac(pendFrac),
    .cnt(cnt), .cycIdx(cycIdx), .polarity(polarity),
    .actPeriod(actPeriod), .pwmOut(pwmOut)
  );
endmodule

// File: tb/tb_pwmfrac_top.sv
`timescale 1ns/1ps
module tb_pwmfrac_top;
  typedef struct {
    int    len;
    int    act;
    bit    pol;
    string req;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] wrData = '0;
  logic       wrPeriodLo = 1'b0, wrPeriodHi = 1'b0;
  logic       wrDutyLo = 1'b0, wrDutyHi = 1'b0, wrFrac = 1'b0;
  logic       polarity = 1'b0;
  logic       pwmOut;

  int    checks = 0;
  int    fails = 0;
  int    tickMode = 0;  // 0 off, 1 every cycle, 2 every other cycle
  bit    monDone = 1'b1;
  bit    finished = 1'b0;
  item_t expQ[$];
  event  goEv;

  pwmfrac_top dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrData(wrData),
    .wrPeriodLo(wrPeriodLo), .wrPeriodHi(wrPeriodHi),
    .wrDutyLo(wrDutyLo), .wrDutyHi(wrDutyHi), .wrFrac(wrFrac),
    .polarity(polarity), .pwmOut(pwmOut)
  );

  always #5 clk = ~clk;

  // tick generator, updates away from the sampling edge
  always @(posedge clk) begin
    #2;
    case (tickMode)
      1:       tickEn = 1'b1;
      2:       tickEn = ~tickEn;
      default: tickEn = 1'b0;
    endcase
  end

  task automatic wrStrobe(input int which, input logic [3:0] d);
    @(negedge clk);
    wrData = d;
    case (which)
      0: wrPeriodLo = 1'b1;
      1: wrPeriodHi = 1'b1;
      2: wrDutyLo   = 1'b1;
      3: wrDutyHi   = 1'b1;
      default: wrFrac = 1'b1;
    endcase
    @(negedge clk);
    {wrPeriodLo, wrPeriodHi, wrDutyLo, wrDutyHi, wrFrac} = '0;
  endtask

  task automatic setPeriod(input logic [7:0] p);
    wrStrobe(0, p[3:0]);
    wrStrobe(1, p[7:4]);
  endtask

  task automatic setDuty(input logic [7:0] d, input logic [1:0] f);
    wrStrobe(4, {2'b00, f});
    wrStrobe(2, d[3:0]);
    wrStrobe(3, d[7:4]);
  endtask

  task automatic resetDut();
    tickMode = 0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input int len, input int act, input bit pol, input string req);
    item_t it;
    it.len = len; it.act = act; it.pol = pol; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic startRun(input int mode);
    monDone = 1'b0;
    -> goEv;
    #1;
    tickMode = mode;
  endtask

  task automatic finishRun();
    wait (monDone);
    tickMode = 0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: one scoreboard item per measured period, counted in ticks
  initial begin
    forever begin
      @(goEv);
      do @(negedge clk); while (!tickEn);
      while (expQ.size() > 0) begin
        item_t it;
        int n, actCnt;
        bit seenIdle, misorder;
        it = expQ.pop_front();
        n = 0; actCnt = 0; seenIdle = 0; misorder = 0;
        while (n < it.len) begin
          @(negedge clk);
          if (tickEn) begin
            if (pwmOut != it.pol) begin
              actCnt++;
              if (seenIdle) misorder = 1;
            end else begin
              seenIdle = 1;
            end
            n++;
          end
        end
        checks++;
        if (actCnt != it.act || misorder) begin
          fails++;
          $display("FAIL %s: active ticks %0d (order ok=%0d), expected %0d active in %0d",
                   it.req, actCnt, !misorder, it.act, it.len);
        end
      end
      monDone = 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    resetDut();
    // R10: reset state is idle (low with polarity 0)
    checks++;
    if (pwmOut !== 1'b0) begin
      fails++;
      $display("FAIL R10: pwmOut=%b expected 0 after reset", pwmOut);
    end

    // R1 R2: period F0, duty 7F, fraction 0
    setPeriod(8'hF0); setDuty(8'h7F, 2'd0);
    for (int i = 0; i < 4; i++) push(240, 127, 0, "R1/R2 base duty");
    startRun(1); finishRun();

    // R3: fraction 3 -> 7F,80,80,80
    resetDut();
    setPeriod(8'hC0); setDuty(8'h7F, 2'd3);
    push(192, 127, 0, "R3 frac3 idx0");
    for (int i = 0; i < 3; i++) push(192, 128, 0, "R3 frac3 idx1-3");
    startRun(1); finishRun();

    // R3: fraction 1 over two groups -> 5,5,5,6
    resetDut();
    setPeriod(8'd20); setDuty(8'd5, 2'd1);
    for (int g = 0; g < 2; g++) begin
      push(20, 5, 0, "R3 frac1"); push(20, 5, 0, "R3 frac1");
      push(20, 5, 0, "R3 frac1"); push(20, 6, 0, "R3 frac1 idx3");
    end
    startRun(1); finishRun();

    // R3: fraction 2 -> 5,5,6,6
    resetDut();
    setPeriod(8'd20); setDuty(8'd5, 2'd2);
    push(20, 5, 0, "R3 frac2"); push(20, 5, 0, "R3 frac2");
    push(20, 6, 0, "R3 frac2"); push(20, 6, 0, "R3 frac2");
    startRun(1); finishRun();

    // R4: inverted polarity, active portion driven low
    resetDut();
    polarity = 1'b1;
    setPeriod(8'd16); setDuty(8'd4, 2'd0);
    for (int i = 0; i < 3; i++) push(16, 4, 1, "R4 polarity low-active");
    startRun(1); finishRun();
    polarity = 1'b0;

    // R5: duty changed mid-period applies from next period
    resetDut();
    setPeriod(8'd20); setDuty(8'd5, 2'd0);
    push(20, 5, 0, "R5 current period kept");
    push(20, 12, 0, "R5 new duty next period");
    push(20, 12, 0, "R5 new duty next period");
    startRun(1);
    repeat (6) @(negedge clk);
    wrStrobe(2, 4'hC); wrStrobe(3, 4'h0);
    finishRun();

    // R6: duty equal to period, and duty+extra reaching period
    resetDut();
    setPeriod(8'd10); setDuty(8'd10, 2'd0);
    for (int i = 0; i < 2; i++) push(10, 10, 0, "R6 full duty");
    startRun(1); finishRun();
    resetDut();
    setPeriod(8'd10); setDuty(8'd9, 2'd3);
    push(10, 9, 0, "R6 clip idx0");
    for (int i = 0; i < 3; i++) push(10, 10, 0, "R6 clip idx1-3");
    startRun(1); finishRun();
    resetDut();
    setPeriod(8'd10); setDuty(8'd0, 2'd0);
    for (int i = 0; i < 2; i++) push(10, 0, 0, "R6 zero duty");
    startRun(1); finishRun();

    // R7: period 0 holds idle, both polarities
    resetDut();
    setPeriod(8'd0); setDuty(8'd5, 2'd2);
    push(24, 0, 0, "R7 stopped idle");
    startRun(1); finishRun();
    polarity = 1'b1;
    push(24, 0, 1, "R7 stopped idle inverted");
    startRun(1); finishRun();
    polarity = 1'b0;

    // R8: staged nibbles without upper write have no effect
    resetDut();
    setPeriod(8'd20); setDuty(8'd5, 2'd0);
    for (int i = 0; i < 4; i++) push(20, 5, 0, "R8 uncommitted staging ignored");
    startRun(1);
    repeat (4) @(negedge clk);
    wrStrobe(0, 4'h5); wrStrobe(4, 4'h3); wrStrobe(2, 4'hA);
    finishRun();

    // R9: ticks only every other cycle, fraction 2 -> 3,3,4,4
    resetDut();
    setPeriod(8'd12); setDuty(8'd3, 2'd2);
    push(12, 3, 0, "R9 sparse ticks"); push(12, 3, 0, "R9 sparse ticks");
    push(12, 4, 0, "R9 sparse ticks"); push(12, 4, 0, "R9 sparse ticks");
    startRun(2); finishRun();

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end
endmodule